// File: doc/BRIEF.md
# Two-Level Translation Lookaside Buffer

This block translates virtual addresses into physical addresses using two cached arrays of page mappings. A small first-level array is searched combinationally. A hit there returns the physical address in the cycle that the request is accepted. A first-level miss goes on to a second-level array with eight times as many entries. The second-level array answers one cycle later, so the translation takes two cycles in total, and the mapping it finds is copied into the first level.

When both levels miss, the block issues a page-walk request carrying the virtual page number, using a valid/ready handshake. It then waits for the walker's refill beat. The refilled mapping is written into both levels and returned to the requester in that same cycle. Each entry maps either a 4kB page or a 2MB page, and the page size decides which address bits are compared and which pass straight through to the output. Each level has its own least-recently-used replacement. A flush input empties both levels in one cycle. Only one lookup may be in flight at a time.

Top module: `tlb2_top`

## Requirements
- R1: After reset, every entry in both levels is invalid and req_ready_o is 1, while resp_valid_o and walk_req_valid_o are 0. The first lookup of any address therefore goes to a page walk.
- R2: If an accepted request hits in the first level, resp_valid_o is 1 in the acceptance cycle and resp_pa_o carries the translated address.
- R3: If a request misses the first level and hits the second level, resp_valid_o is 1 in the cycle after acceptance. The mapping is installed in the first level, so a repeat lookup of that page hits the first level.
- R4: If a request misses both levels, walk_req_valid_o rises in the second cycle after acceptance, and walk_vpn_o equals req_va_i[31:12]. Both are held until walk_req_ready_i is 1. The response appears in the cycle that fill_valid_i is 1, and its address is formed from fill_ppn_i and fill_huge_i.
- R5: req_ready_o is 0 from the cycle after a first-level miss is accepted until the cycle after its response.
- R6: A refill writes its mapping into both levels. In each level it takes the lowest-indexed invalid entry if there is one.
- R7: When the first level is full, an install into it replaces its least recently used entry.
- R8: When the second level is full, a refill replaces its least recently used entry.
- R9: A mapping with fill_huge_i=1 covers 2MB. It matches on va[31:21], and the output is {ppn[19:9], va[20:0]}. A mapping with fill_huge_i=0 covers 4kB. It matches on va[31:12], and the output is {ppn, va[11:0]}.
- R10: A cycle with flush_i=1 invalidates every entry in both levels, and req_ready_o is 0 during that cycle.
- R11: Every hit marks the hit entry as the most recently used entry in the level that hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries in both levels |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_va_i | input | VA_W | Virtual address to translate |
| resp_valid_o | output | 1 | Translation result valid |
| resp_pa_o | output | PA_W | Translated physical address |
| walk_req_valid_o | output | 1 | Page-walk request valid |
| walk_req_ready_i | input | 1 | Walker accepts the request |
| walk_vpn_o | output | VA_W-12 | Virtual page number to walk |
| fill_valid_i | input | 1 | Refill beat from the walker |
| fill_ppn_i | input | PA_W-12 | Physical page number of the refill |
| fill_huge_i | input | 1 | 1: refill maps a 2MB page, 0: a 4kB page |

## Verification
The assertions assume three things about the inputs. flush_i is raised only while the block is idle. fill_valid_i is raised only after the walk request has been accepted. The walker never returns mappings that overlap a page already held in either level. The stimulus keeps to these rules by design. It pulses flush only between lookups, drives the refill beat one cycle after granting walk_req_ready_i, and places every page at a distinct address, with the 2MB pages in regions that no 4kB page uses.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  localparam int SMALL_OFF_W = 12;
  localparam int LARGE_OFF_W = 21;
  localparam int HUGE_SPLIT  = LARGE_OFF_W - SMALL_OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_L2,
    ST_WREQ,
    ST_WAIT
  } tlb_state_e;
endpackage

// File: rtl/tlb2_lru.sv
module tlb2_lru #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] lru_idx_o
);
  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == IW'(N - 1)) lru_idx_o = IW'(i);
  end
endmodule

// File: rtl/tlb2_array.sv
module tlb2_array
  import tlb2_pkg::*;
#(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_touch_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic             hit_huge_o,
  input  logic             wr_en_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             wr_huge_i
);
  logic [N-1:0]     valid_q;
  logic [N-1:0]     huge_q;
  logic [VPN_W-1:0] vpn_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     match;
  logic [IW-1:0]    hit_idx, vic_idx, lru_idx, touch_idx;
  logic             touch_en;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic hi_eq, lo_eq;
    assign hi_eq    = vpn_q[g][VPN_W-1:HUGE_SPLIT] == lk_vpn_i[VPN_W-1:HUGE_SPLIT];
    assign lo_eq    = vpn_q[g][HUGE_SPLIT-1:0] == lk_vpn_i[HUGE_SPLIT-1:0];
    assign match[g] = valid_q[g] & hi_eq & (huge_q[g] | lo_eq);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match[i]) hit_idx = IW'(i);
  end

  assign hit_o      = |match;
  assign hit_ppn_o  = ppn_q[hit_idx];
  assign hit_huge_o = huge_q[hit_idx];

  // lowest invalid slot first, else least recently used
  always_comb begin
    vic_idx = lru_idx;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_q[i]) vic_idx = IW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      huge_q  <= '0;
      for (int i = 0; i < N; i++) begin
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[vic_idx] <= 1'b1;
      huge_q[vic_idx]  <= wr_huge_i;
      vpn_q[vic_idx]   <= wr_vpn_i;
      ppn_q[vic_idx]   <= wr_ppn_i;
    end
  end

  assign touch_en  = ~flush_i & (wr_en_i | (lk_touch_i & hit_o));
  assign touch_idx = wr_en_i ? vic_idx : hit_idx;

  tlb2_lru #(.N(N)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (touch_en),
    .touch_idx_i(touch_idx),
    .lru_idx_o  (lru_idx)
  );
endmodule

// File: rtl/tlb2_top.sv
module tlb2_top
  import tlb2_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int L1_ENTRIES = 8,
  parameter int L2_RATIO   = 8,
  localparam int VPN_W      = VA_W - SMALL_OFF_W,
  localparam int PPN_W      = PA_W - SMALL_OFF_W,
  localparam int L2_ENTRIES = L1_ENTRIES * L2_RATIO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  output logic             resp_valid_o,
  output logic [PA_W-1:0]  resp_pa_o,
  output logic             walk_req_valid_o,
  input  logic             walk_req_ready_i,
  output logic [VPN_W-1:0] walk_vpn_o,
  input  logic             fill_valid_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_huge_i
);
  tlb_state_e      state_q, state_d;
  logic [VA_W-1:0] va_q;

  logic             accept, fill_take;
  logic             l1_hit, l1_huge, l1_wr;
  logic [PPN_W-1:0] l1_ppn, l1_wr_ppn;
  logic             l1_wr_huge;
  logic             l2_hit, l2_huge, l2_wr;
  logic [PPN_W-1:0] l2_ppn;

  function automatic logic [PA_W-1:0] compose(logic [PPN_W-1:0] ppn, logic huge,
                                              logic [VA_W-1:0] va);
    if (huge) return {ppn[PPN_W-1:HUGE_SPLIT], va[LARGE_OFF_W-1:0]};
    return {ppn, va[SMALL_OFF_W-1:0]};
  endfunction

  assign req_ready_o = (state_q == ST_IDLE) & ~flush_i;
  assign accept      = req_valid_i & req_ready_o;
  assign fill_take   = (state_q == ST_WAIT) & fill_valid_i;

  // L1 installs: from an L2 hit or from a refill
  assign l1_wr      = ((state_q == ST_L2) & l2_hit) | fill_take;
  assign l1_wr_ppn  = fill_take ? fill_ppn_i : l2_ppn;
  assign l1_wr_huge = fill_take ? fill_huge_i : l2_huge;
  assign l2_wr      = fill_take;

  tlb2_array #(.N(L1_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l1 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lk_vpn_i  (req_va_i[VA_W-1:SMALL_OFF_W]),
    .lk_touch_i(accept),
    .hit_o     (l1_hit),
    .hit_ppn_o (l1_ppn),
    .hit_huge_o(l1_huge),
    .wr_en_i   (l1_wr),
    .wr_vpn_i  (va_q[VA_W-1:SMALL_OFF_W]),
    .wr_ppn_i  (l1_wr_ppn),
    .wr_huge_i (l1_wr_huge)
  );

  tlb2_array #(.N(L2_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l2 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lk_vpn_i  (va_q[VA_W-1:SMALL_OFF_W]),
    .lk_touch_i(state_q == ST_L2),
    .hit_o     (l2_hit),
    .hit_ppn_o (l2_ppn),
    .hit_huge_o(l2_huge),
    .wr_en_i   (l2_wr),
    .wr_vpn_i  (va_q[VA_W-1:SMALL_OFF_W]),
    .wr_ppn_i  (fill_ppn_i),
    .wr_huge_i (fill_huge_i)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && !l1_hit) state_d = ST_L2;
      ST_L2:   state_d = l2_hit ? ST_IDLE : ST_WREQ;
      ST_WREQ: if (walk_req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (fill_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) va_q <= req_va_i;
    end
  end

  always_comb begin
    resp_valid_o = 1'b0;
    resp_pa_o    = '0;
    unique case (state_q)
      ST_IDLE: begin
        resp_valid_o = accept & l1_hit;
        resp_pa_o    = compose(l1_ppn, l1_huge, req_va_i);
      end
      ST_L2: begin
        resp_valid_o = l2_hit;
        resp_pa_o    = compose(l2_ppn, l2_huge, va_q);
      end
      ST_WAIT: begin
        resp_valid_o = fill_valid_i;
        resp_pa_o    = compose(fill_ppn_i, fill_huge_i, va_q);
      end
      default: ;
    endcase
  end

  assign walk_req_valid_o = (state_q == ST_WREQ);
  assign walk_vpn_o       = va_q[VA_W-1:SMALL_OFF_W];
endmodule

// File: rtl/tlb2_checker.sv
module tlb2_checker #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  localparam int VPN_W = VA_W - 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_va_i,
  input logic             resp_valid_o,
  input logic [PA_W-1:0]  resp_pa_o,
  input logic             walk_req_valid_o,
  input logic             walk_req_ready_i,
  input logic [VPN_W-1:0] walk_vpn_o,
  input logic             fill_valid_i
);
  AST_IDLE_RESP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && resp_valid_o) |-> req_valid_i);  // R2

  AST_IDLE_RESP_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && resp_valid_o) |-> resp_pa_o[11:0] == req_va_i[11:0]);  // R9

  AST_MISS_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !resp_valid_o) |=> !req_ready_o);  // R5

  AST_WALK_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_valid_o |-> !req_ready_o);  // R5

  AST_WALK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_valid_o && !walk_req_ready_i) |=> walk_req_valid_o && $stable(walk_vpn_o));  // R4

  AST_FILL_RESPONDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> resp_valid_o);  // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !resp_valid_o);  // R10
endmodule

bind tlb2_top tlb2_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .flush_i         (flush_i),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_va_i        (req_va_i),
  .resp_valid_o    (resp_valid_o),
  .resp_pa_o       (resp_pa_o),
  .walk_req_valid_o(walk_req_valid_o),
  .walk_req_ready_i(walk_req_ready_i),
  .walk_vpn_o      (walk_vpn_o),
  .fill_valid_i    (fill_valid_i)
);

// File: tb/tlb2_top_test.sv
module tlb2_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        resp_valid;
  logic [31:0] resp_pa;
  logic        walk_valid;
  logic        walk_ready = 1'b0;
  logic [19:0] walk_vpn;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_ppn = '0;
  logic        fill_huge = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  tlb2_top uut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .flush_i         (flush),
    .req_valid_i     (req_valid),
    .req_ready_o     (req_ready),
    .req_va_i        (req_va),
    .resp_valid_o    (resp_valid),
    .resp_pa_o       (resp_pa),
    .walk_req_valid_o(walk_valid),
    .walk_req_ready_i(walk_ready),
    .walk_vpn_o      (walk_vpn),
    .fill_valid_i    (fill_valid),
    .fill_ppn_i      (fill_ppn),
    .fill_huge_i     (fill_huge)
  );

  // path: 0 = first-level hit, 1 = second-level hit, 2 = page walk
  localparam int NV = 16;
  localparam logic [31:0] T_VA [NV] = '{
    32'h0000_1234, 32'h0000_1FFF, 32'h0041_2345, 32'h005F_FFFF,
    32'h1000_25A0, 32'h1000_35A0, 32'h1000_45A0, 32'h1000_55A0,
    32'h1000_65A0, 32'h1000_75A0, 32'h0000_1000, 32'h1000_85A0,
    32'h0040_0000, 32'h0000_1ABC, 32'h1000_2ABC, 32'h0061_2345};
  localparam logic [19:0] T_PPN [NV] = '{
    20'h00ABC, 20'h0, 20'h123FF, 20'h0,
    20'h20002, 20'h20003, 20'h20004, 20'h20005,
    20'h20006, 20'h20007, 20'h0, 20'h20008,
    20'h0, 20'h0, 20'h0, 20'h0C0DE};
  localparam logic T_HUGE [NV] = '{
    1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam int T_PATH [NV] = '{2, 0, 2, 0, 2, 2, 2, 2, 2, 2, 0, 2, 1, 0, 1, 2};
  localparam logic [31:0] T_PA [NV] = '{
    32'h00AB_C234, 32'h00AB_CFFF, 32'h1221_2345, 32'h123F_FFFF,
    32'h2000_25A0, 32'h2000_35A0, 32'h2000_45A0, 32'h2000_55A0,
    32'h2000_65A0, 32'h2000_75A0, 32'h00AB_C000, 32'h2000_85A0,
    32'h1220_0000, 32'h00AB_CABC, 32'h2000_2ABC, 32'h0C0D_E345};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [19:0] ppn, input logic huge,
                        input int exp_path, input logic [31:0] exp_pa, input string req);
    int path;
    logic [31:0] pa;
    int g;
    path = -1;
    pa   = '0;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    #1;
    chk(req_ready, "R5", "ready when idle", 32'(req_ready), 32'd1);
    if (resp_valid) begin
      path = 0;
      pa   = resp_pa;
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (path < 0) begin
      chk(!req_ready, "R5", "ready after miss", 32'(req_ready), 32'd0);
      if (resp_valid) begin
        path = 1;
        pa   = resp_pa;
      end else begin
        chk(!walk_valid, "R4", "walk one cycle early", 32'(walk_valid), 32'd0);
        @(negedge clk);
        #1;
        chk(walk_valid, "R4", "walk request raised", 32'(walk_valid), 32'd1);
        chk(walk_vpn == va[31:12], "R4", "walk vpn", 32'(walk_vpn), 32'(va[31:12]));
        g = 0;
        while (!walk_valid && g < 20) begin
          @(negedge clk);
          #1;
          g++;
        end
        repeat (2) begin
          @(negedge clk);
          #1;
          chk(walk_valid && !req_ready, "R4", "walk held", 32'(walk_valid), 32'd1);
        end
        @(negedge clk);
        walk_ready = 1'b1;
        @(negedge clk);
        walk_ready = 1'b0;
        fill_valid = 1'b1;
        fill_ppn   = ppn;
        fill_huge  = huge;
        #1;
        if (resp_valid) begin
          path = 2;
          pa   = resp_pa;
        end
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        chk(req_ready, "R5", "ready after response", 32'(req_ready), 32'd1);
      end
    end
    chk(path == exp_path, req, "path", 32'(path), 32'(exp_path));
    chk(pa == exp_pa, req, "physical address", pa, exp_pa);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready, "R1", "reset ready", 32'(req_ready), 32'd1);
    chk(!resp_valid && !walk_valid, "R1", "reset outputs", {30'd0, resp_valid, walk_valid}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tg;
      if (i == 0) tg = "R1";
      else if (i == 13) tg = "R11";
      else if (i >= 11 && i <= 14) tg = "R7";
      else if (i == 2 || i == 3 || i == 15) tg = "R9";
      else if (T_PATH[i] == 0) tg = "R2";
      else if (T_PATH[i] == 1) tg = "R3";
      else tg = "R6";
      lookup(T_VA[i], T_PPN[i], T_HUGE[i], T_PATH[i], T_PA[i], tg);
    end

    // R3: page brought from L2 now hits L1
    lookup(32'h1000_2001, 20'h0, 1'b0, 0, 32'h2000_2001, "R3");

    // R10: flush empties both levels
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(!req_ready, "R10", "ready during flush", 32'(req_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    lookup(32'h0000_1234, 20'h00ABC, 1'b0, 2, 32'h00AB_C234, "R10");
    lookup(32'h1000_85A0, 20'h20008, 1'b0, 2, 32'h2000_85A0, "R10");
    lookup(32'h0000_1234, 20'h0, 1'b0, 0, 32'h00AB_C234, "R6");

    // R8: second-level LRU
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int q = 0; q < 64; q++)
      lookup(32'h4000_007C | (q << 12), 20'h30000 + 20'(q), 1'b0, 2,
             32'h3000_007C | (q << 12), "R6");
    lookup(32'h4000_007C, 20'h0, 1'b0, 1, 32'h3000_007C, "R11");
    lookup(32'h4004_007C, 20'h30040, 1'b0, 2, 32'h3004_007C, "R8");
    lookup(32'h4000_107C, 20'h30001, 1'b0, 2, 32'h3000_107C, "R8");
    lookup(32'h4000_007C, 20'h0, 1'b0, 0, 32'h3000_007C, "R3");
    lookup(32'h4000_307C, 20'h0, 1'b0, 1, 32'h3000_307C, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule